// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block keeps an SDRAM refreshed on behalf of a memory controller. A free-running interval timer adds one unit of refresh debt every `INTERVAL_CYC` clock cycles, for example 15.6 µs times the clock frequency. While any debt is owed, the block raises a bus request towards the main command scheduler. The main scheduler may defer the grant, which postpones refreshes and lets the debt build up. The debt saturates at `MAX_DEBT` (eight). At that point the request is flagged urgent, and the main scheduler must not defer it any longer.

Once the grant is sampled high, the block takes the command bus. If some bank is still open (`banks_idle` low), it first sends a precharge-all command and waits tRP. It then sends auto-refresh commands back to back, each followed by tRFC of NOP cycles, until the debt is cleared. After that it drops `busy` and `bus_req` and returns the bus. No refresh address is driven because the device counts rows internally; only the A10 line is driven, to select all banks for the precharge.

The control pins are plain levels. There is no data stream: the grant is a level that the block samples only while it is idle and owes debt. Once the block has started, it ignores the grant until it releases the bus. While it does not own the bus, it drives deselect.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset, `cmd_cs_n` is 1 (deselect), `cmd_cke` is 1, and `bus_req`, `req_urgent` and `busy` are 0.
- R2: One debt unit is added every `INTERVAL_CYC` cycles. While debt is nonzero and the grant is withheld, `bus_req` stays high and no command is issued.
- R3: The debt saturates at `MAX_DEBT`. `req_urgent` is 1 exactly when the debt equals `MAX_DEBT`, and ticks arriving at saturation are lost.
- R4: If the grant is sampled high while idle, with debt owed and `banks_idle` high, the next cycle carries auto-refresh: CS#=0, RAS#=0, CAS#=0, WE#=1, CKE=1.
- R5: If the grant is sampled with `banks_idle` low, the next cycle carries precharge-all: CS#=0, RAS#=0, CAS#=1, WE#=0, A10=1. The refresh follows exactly `T_RP` cycles later.
- R6: Every cycle between commands while busy is NOP (CS#=0, RAS#/CAS#/WE#=1). No command follows a refresh sooner than `T_RFC` cycles.
- R7: All owed refreshes go out in one burst, spaced exactly `T_RFC` apart. After the wait that follows the last one, `busy` and `bus_req` fall once the debt is zero.
- R8: An interval tick in the same cycle as a refresh leaves the debt unchanged, so one more refresh follows in the same burst.
- R9: When the grant is given as soon as `req_urgent` rises, no two refreshes are more than 8 intervals apart, plus at most three cycles of latency.
- R10: `bus_req` is high in every cycle in which `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_grant | input | 1 | Command bus granted by the main scheduler |
| banks_idle | input | 1 | All banks precharged and past tRP |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_cke | output | 1 | Clock enable, held high |
| cmd_a10 | output | 1 | All-banks select for precharge |
| bus_req | output | 1 | Request for the command bus |
| req_urgent | output | 1 | Debt saturated, grant must not be deferred |
| busy | output | 1 | Block owns the command bus |

## Verification
The interval tick that adds debt and the refresh that retires debt can land in the same cycle. If that case is handled wrongly, one refresh is silently lost or one is added. The bench provokes it by timing the grant from the edge at which `bus_req` rose, so that the refresh cycle ends on the next tick edge. It then expects two refreshes exactly `T_RFC` apart before the bus is released, instead of one.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRECH,
    ST_WAIT_RP,
    ST_REFRESH,
    ST_WAIT_RFC
  } ref_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdr_cmd_t;

  localparam sdr_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdr_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdr_cmd_t CMD_REF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam sdr_cmd_t CMD_PRE   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int INTERVAL_CYC = 1950
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = (cnt == LAST);

  // R2: ticks are never adjacent
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/ref_debt_counter.sv
module ref_debt_counter #(
  parameter int MAX_DEBT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic dec,
  output logic pending,
  output logic full
);
  localparam int DW = $clog2(MAX_DEBT + 1);
  localparam logic [DW-1:0] TOP = DW'(MAX_DEBT);

  logic [DW-1:0] debt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      debt <= '0;
    end else if (tick && !dec) begin
      if (debt != TOP) debt <= debt + 1'b1;
    end else if (dec && !tick) begin
      debt <= debt - 1'b1;
    end
  end

  assign pending = (debt != '0);
  assign full    = (debt == TOP);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    debt <= TOP);

  // R7: a refresh never retires debt that is not owed
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> pending);

  a_r8_tick_and_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dec) |=> $stable(debt));

endmodule

// File: rtl/ref_cmd_fsm.sv
module ref_cmd_fsm
  import sdram_ref_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_RFC = 9
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     grant,
  input  logic     banks_idle,
  input  logic     pending,
  output sdr_cmd_t cmd,
  output logic     a10,
  output logic     ref_fire,
  output logic     busy
);
  localparam int WMAX = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int WW   = $clog2(WMAX) + 1;
  localparam logic [WW-1:0] RP_LOAD  = WW'(T_RP - 2);
  localparam logic [WW-1:0] RFC_LOAD = WW'(T_RFC - 2);

  ref_state_e state, state_n;
  logic [WW-1:0] wcnt, wcnt_n;

  always_comb begin
    state_n = state;
    wcnt_n  = wcnt;
    unique case (state)
      ST_IDLE: begin
        if (pending && grant) state_n = banks_idle ? ST_REFRESH : ST_PRECH;
      end
      ST_PRECH: begin
        state_n = ST_WAIT_RP;
        wcnt_n  = RP_LOAD;
      end
      ST_WAIT_RP: begin
        if (wcnt == '0) state_n = ST_REFRESH;
        else            wcnt_n  = wcnt - 1'b1;
      end
      ST_REFRESH: begin
        state_n = ST_WAIT_RFC;
        wcnt_n  = RFC_LOAD;
      end
      ST_WAIT_RFC: begin
        if (wcnt == '0) state_n = pending ? ST_REFRESH : ST_IDLE;
        else            wcnt_n  = wcnt - 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      wcnt  <= '0;
    end else begin
      state <= state_n;
      wcnt  <= wcnt_n;
    end
  end

  always_comb begin
    a10 = 1'b0;
    unique case (state)
      ST_IDLE:    cmd = CMD_DESEL;
      ST_PRECH:   begin cmd = CMD_PRE; a10 = 1'b1; end
      ST_REFRESH: cmd = CMD_REF;
      default:    cmd = CMD_NOP;
    endcase
  end

  assign ref_fire = (state == ST_REFRESH);
  assign busy     = (state != ST_IDLE);

  a_r4_grant_to_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pending && grant && banks_idle) |=> (cmd == CMD_REF));

  a_r5_grant_to_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pending && grant && !banks_idle) |=> (cmd == CMD_PRE && a10));

  a_r6_nop_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF) |=> (cmd == CMD_NOP));

  a_r5_nop_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |=> (cmd == CMD_NOP));

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_ref_pkg::*;
#(
  parameter int INTERVAL_CYC = 1950,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 9,
  parameter int MAX_DEBT     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_grant,
  input  logic banks_idle,
  output logic cmd_cs_n,
  output logic cmd_ras_n,
  output logic cmd_cas_n,
  output logic cmd_we_n,
  output logic cmd_cke,
  output logic cmd_a10,
  output logic bus_req,
  output logic req_urgent,
  output logic busy
);
  logic     tick, ref_fire, pending, full, fsm_busy;
  sdr_cmd_t cmd;

  ref_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  ref_debt_counter #(.MAX_DEBT(MAX_DEBT)) u_debt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dec(ref_fire),
    .pending(pending), .full(full)
  );

  ref_cmd_fsm #(.T_RP(T_RP), .T_RFC(T_RFC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .grant(bus_grant), .banks_idle(banks_idle),
    .pending(pending), .cmd(cmd), .a10(cmd_a10), .ref_fire(ref_fire),
    .busy(fsm_busy)
  );

  assign cmd_cs_n   = cmd.cs_n;
  assign cmd_ras_n  = cmd.ras_n;
  assign cmd_cas_n  = cmd.cas_n;
  assign cmd_we_n   = cmd.we_n;
  assign cmd_cke    = 1'b1;
  assign busy       = fsm_busy;
  assign bus_req    = pending | fsm_busy;
  assign req_urgent = full;

  a_r7_release_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(pending));

  a_r3_urgent_requests: assert property (@(posedge clk) disable iff (!rst_n)
    req_urgent |-> bus_req);

endmodule

// File: tb/sdram_refresh_sched_test.sv
`timescale 1ns/1ps
module sdram_refresh_sched_test;
  localparam int IV   = 100;
  localparam int TRP  = 3;
  localparam int TRFC = 8;
  localparam int MAXD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_grant = 1'b0;
  logic banks_idle = 1'b1;
  logic cs_n, ras_n, cas_n, we_n, cke, a10, bus_req, req_urgent, busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit gap_en = 1'b1;
  int exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_refresh_sched #(.INTERVAL_CYC(IV), .T_RP(TRP), .T_RFC(TRFC), .MAX_DEBT(MAXD)) uut (
    .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .banks_idle(banks_idle),
    .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .cmd_cke(cke), .cmd_a10(a10), .bus_req(bus_req), .req_urgent(req_urgent),
    .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // 0 deselect, 1 nop, 2 precharge-all, 3 refresh, 4 other
  function automatic int decode();
    if (cs_n) return 0;
    if (!ras_n && !cas_n && we_n && cke) return 3;
    if (!ras_n && cas_n && !we_n && a10) return 2;
    if (ras_n && cas_n && we_n) return 1;
    return 4;
  endfunction

  // Monitor / scoreboard
  int last_kind = 0;
  int last_cyc = 0;
  int last_ref = -1;
  bit busy_dropped = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int k;
      k = decode();
      if (busy) begin
        chk(bus_req, "R10 bus_req while busy", bus_req, 1);
        chk(k != 0 && k != 4, "R6 legal command while busy", k, 1);
      end else begin
        busy_dropped = 1'b1;
      end
      if (k == 2 || k == 3) begin
        if (exp_q.size() == 0) begin
          chk(0, "R2 unexpected command", k, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(k == e, (k == 3) ? "R4 command kind" : "R5 command kind", k, e);
        end
        if (k == 3 && last_kind == 2)
          chk(cyc - last_cyc == TRP, "R5 precharge to refresh", cyc - last_cyc, TRP);
        if (last_kind == 3 && !busy_dropped)
          chk(cyc - last_cyc == TRFC, "R7 burst spacing", cyc - last_cyc, TRFC);
        else if (last_kind == 3)
          chk(cyc - last_cyc >= TRFC, "R6 refresh recovery", cyc - last_cyc, TRFC);
        if (k == 3) begin
          if (gap_en && last_ref >= 0)
            chk(cyc - last_ref <= 8 * IV + 3, "R9 max refresh gap", cyc - last_ref, 8 * IV + 3);
          last_ref = cyc;
        end
        last_kind = k;
        last_cyc = cyc;
        busy_dropped = 1'b0;
      end
    end
  end

  task automatic wait_req();
    while (!bus_req) @(negedge clk);
  endtask

  task automatic serve(input bit idle_banks, input int n_ref);
    banks_idle = idle_banks;
    if (!idle_banks) exp_q.push_back(2);
    for (int i = 0; i < n_ref; i++) exp_q.push_back(3);
    bus_grant = 1'b1;
    @(negedge clk);
    while (busy) @(negedge clk);
    bus_grant = 1'b0;
    banks_idle = 1'b1;
    chk(!bus_req, "R7 bus released", bus_req, 0);
    chk(exp_q.size() == 0, "R7 all refreshes issued", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1 cs_n deselect", cs_n, 1);
    chk(cke == 1'b1, "R1 cke high", cke, 1);
    chk(!bus_req && !req_urgent && !busy, "R1 idle flags", {bus_req, req_urgent, busy}, 0);
    rst_n = 1'b1;

    // R2: first interval raises the request; withheld grant issues nothing
    repeat (IV - 5) @(negedge clk);
    chk(!bus_req, "R2 no request before interval", bus_req, 0);
    wait_req();
    repeat (20) @(negedge clk);
    chk(bus_req && !busy && cs_n, "R2 request held without grant", {bus_req, busy, cs_n}, 3'b101);
    chk(!req_urgent, "R3 not urgent at debt 1", req_urgent, 0);

    // R4: banks idle -> single refresh
    serve(1'b1, 1);

    // R5: banks open -> precharge-all then refresh
    wait_req();
    serve(1'b0, 1);

    // R3: saturation and urgency, grant deferred past saturation
    gap_en = 1'b0;
    wait_req();
    repeat (6 * IV) @(negedge clk);
    chk(!req_urgent, "R3 not urgent at debt 7", req_urgent, 0);
    repeat (IV) @(negedge clk);
    chk(req_urgent, "R3 urgent at debt 8", req_urgent, 1);
    repeat (IV) @(negedge clk);
    chk(req_urgent, "R3 still urgent when saturated", req_urgent, 1);
    serve(1'b1, MAXD);
    chk(!req_urgent, "R3 urgency cleared", req_urgent, 0);
    gap_en = 1'b1;

    // R9: prompt grant when urgent keeps the gap bounded
    while (!req_urgent) @(negedge clk);
    serve(1'b1, MAXD);

    // R8: refresh cycle coincides with a tick -> one extra refresh
    wait_req();
    repeat (IV - 2) @(negedge clk);
    serve(1'b1, 2);

    repeat (5) @(negedge clk);
    chk(!busy && cs_n, "R7 idle after bursts", {busy, cs_n}, 2'b01);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule